// File: doc/BRIEF.md
# Eight-Lane Interleaved ADC Sample Demapper

This block sits behind the receive side of a serial converter link whose eight lanes have already been aligned, decoded and descrambled. Each lane hands over four octets per clock on a 32-bit word, with the earliest octet in the low byte. One lane frame is eight octets long, so it spans two consecutive words. The frame carries five 12-bit samples and closes with four tail bits. The eight lanes are eight time-interleaved phases of a single fast converter. Lane k holds phase k.

The demapper joins the two words of each lane frame and strips the tail bits. It then slices out the five samples and interleaves the eight lanes back into time order. Each frame period it presents forty samples at once, together with a one-cycle valid strobe. A frame-start input marks the first word of a frame and sets the frame boundary. After that the block keeps alternating between first and second words until another frame-start moves the boundary. A per-lane invert bit corrects lanes whose differential pairs are wired with swapped polarity.

Top module: `jesd_lane_demapper`

## Requirements
- R1: While reset is held, and after it is released, `sample_valid` is low and `samples` is all zero. No valid pulse appears until a `frame_start` has been seen, whatever data is driven.
- R2: A lane frame is read as a 64-bit stream. It starts with the low byte of the first word, continues upward through the bytes of that word, and then runs through the bytes of the second word from low byte to high. Each octet is read most significant bit first. Lane sample j (j = 0 to 4) is stream bits 12j to 12j+11, and the first of these bits is the sample's MSB.
- R3: The last 4 bits of each lane frame, which are the low nibble of the second word's high byte, have no effect on any output sample.
- R4: Output sample n sits at `samples[12n+11:12n]`. For n = 8j + k, it is lane sample j of lane k.
- R5: `sample_valid` is high for exactly one cycle, in the cycle after the second word of a frame is accepted. With continuous data after a single `frame_start`, it pulses every second cycle and never on two cycles in a row.
- R6: A `frame_start` makes the word presented in that cycle the first word of a new frame, even if a second word was expected there. No valid pulse follows that cycle.
- R7: When `lane_invert[k]` is 1, every bit of lane k's word is complemented before unpacking. The other lanes are unaffected.
- R8: Between valid pulses, `samples` holds the value captured at the last pulse.
- R9: Samples are passed as raw 12-bit two's complement codes, with no sign conversion. For example, 12'h800 comes out as 12'h800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-side clock, one word per lane per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_data | input | 256 | Lane k word at bits [32k+31:32k], earliest octet in the low byte |
| frame_start | input | 1 | High in the cycle that carries the first word of a frame |
| lane_invert | input | 8 | Bit k complements all bits received on lane k |
| sample_valid | output | 1 | One-cycle strobe marking a new set of 40 samples |
| samples | output | 480 | Output sample n at bits [12n+11:12n], in time order |

## Verification
The bench builds the block with its default parameters: eight lanes, 32-bit words, five 12-bit samples per frame, and therefore 40 output samples. With these values every lane-to-position mapping and every boundary where a sample straddles the two words is reachable. That includes sample 2, which is split across the word boundary, and the tail nibble. Directed frames cover extreme two's complement codes, changed tail bits, back-to-back streaming, a boundary that moves mid-frame, a mixed inversion mask, and a reset in the middle of a stream.

// File: rtl/demap_pkg.sv
// Shared definitions for the lane sample demapper.
// Assumes a lane frame always spans exactly two words.
package demap_pkg;
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } word_phase_t;
endpackage

// File: rtl/demap_ctrl.sv
// Word-phase controller: tracks whether the current word is the first or
// second of a lane frame. It locks on the first frame_start after reset.
// Assumes a word arrives on every clock once the link is up.
module demap_ctrl
    import demap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    output logic load_first,
    output logic capture
);
    word_phase_t phase_q;
    logic        locked_q;

    // Decide whether this word opens a frame or closes one.
    always_comb begin
        load_first = frame_start || (locked_q && phase_q == PH_FIRST);
        capture    = !frame_start && locked_q && phase_q == PH_SECOND;
    end

    // Advance the phase; frame_start always forces a new boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_FIRST;
            locked_q <= 1'b0;
        end else if (frame_start) begin
            phase_q  <= PH_SECOND;
            locked_q <= 1'b1;
        end else if (locked_q) begin
            phase_q  <= (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
        end
    end
endmodule

// File: rtl/lane_gather.sv
// Per-lane frame gatherer: applies the polarity correction, holds the first
// word, and joins it with the current word into one frame-ordered vector.
// The first-received octet ends up in the frame MSBs.
// Assumes WORD_W is a whole number of octets.
module lane_gather #(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WORD_W-1:0]   word_in,
    input  logic                invert,
    input  logic                load_first,
    output logic [2*WORD_W-1:0] frame_out
);
    localparam int OCTETS  = WORD_W / 8;
    localparam int FRAME_W = 2 * WORD_W;

    logic [WORD_W-1:0] word_fix;
    logic [WORD_W-1:0] first_q;

    // Undo swapped pair polarity when configured.
    always_comb word_fix = invert ? ~word_in : word_in;

    // Hold the first word of the frame in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)          first_q <= '0;
        else if (load_first) first_q <= word_fix;
    end

    // Place octets in arrival order, earliest at the top of the frame.
    for (genvar o = 0; o < OCTETS; o++) begin : g_oct
        assign frame_out[FRAME_W-1-8*o -: 8]          = first_q[8*o +: 8];
        assign frame_out[FRAME_W-1-8*(o+OCTETS) -: 8] = word_fix[8*o +: 8];
    end
endmodule

// File: rtl/frame_unpack.sv
// Frame unpacker: slices SPF samples of SMP_W bits off the top of a frame.
// The leftover low bits are the tail and are dropped.
// Assumes SPF*SMP_W <= FRAME_W.
module frame_unpack #(
    parameter int FRAME_W = 64,
    parameter int SMP_W   = 12,
    parameter int SPF     = 5
) (
    input  logic [FRAME_W-1:0]   frame_in,
    output logic [SPF*SMP_W-1:0] smp_out
);
    localparam int TAIL_W = FRAME_W - SPF * SMP_W;

    logic [TAIL_W-1:0] tail_unused;

    // The tail is taken off explicitly so that it is visibly dropped.
    assign tail_unused = frame_in[TAIL_W-1:0];

    // Sample j is taken from the MSB end of the frame, in order.
    for (genvar j = 0; j < SPF; j++) begin : g_smp
        assign smp_out[SMP_W*j +: SMP_W] = frame_in[FRAME_W-1-SMP_W*j -: SMP_W];
    end
endmodule

// File: rtl/jesd_lane_demapper.sv
// Top level: gathers a two-word frame on every lane, unpacks the samples,
// and interleaves the lanes into time order. Output n = LANES*j + k.
// Assumes the lanes are already aligned to each other and to octets.
module jesd_lane_demapper #(
    parameter int LANES  = 8,
    parameter int WORD_W = 32,
    parameter int SMP_W  = 12,
    parameter int SPF    = 5,
    localparam int FRAME_W = 2 * WORD_W,
    localparam int NSMP    = LANES * SPF,
    localparam int OUT_W   = NSMP * SMP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*WORD_W-1:0] lane_data,
    input  logic                    frame_start,
    input  logic [LANES-1:0]        lane_invert,
    output logic                    sample_valid,
    output logic [OUT_W-1:0]        samples
);
    logic                   load_first;
    logic                   capture;
    logic [FRAME_W-1:0]     lane_frame [LANES];
    logic [SPF*SMP_W-1:0]   lane_smp   [LANES];
    logic [OUT_W-1:0]       ordered;

    demap_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .load_first  (load_first),
        .capture     (capture)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_gather #(.WORD_W(WORD_W)) u_gather (
            .clk        (clk),
            .rst_n      (rst_n),
            .word_in    (lane_data[WORD_W*k +: WORD_W]),
            .invert     (lane_invert[k]),
            .load_first (load_first),
            .frame_out  (lane_frame[k])
        );

        frame_unpack #(.FRAME_W(FRAME_W), .SMP_W(SMP_W), .SPF(SPF)) u_unpack (
            .frame_in (lane_frame[k]),
            .smp_out  (lane_smp[k])
        );

        // Sample j of lane k lands at time slot LANES*j + k.
        for (genvar j = 0; j < SPF; j++) begin : g_slot
            assign ordered[SMP_W*(LANES*j+k) +: SMP_W] = lane_smp[k][SMP_W*j +: SMP_W];
        end
    end

    // Register the ordered samples and the strobe at frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_valid <= 1'b0;
            samples      <= '0;
        end else begin
            sample_valid <= capture;
            if (capture) samples <= ordered;
        end
    end
endmodule

// File: rtl/demap_checker.sv
// Property checker for the demapper, bound to the top module.
module demap_checker #(
    parameter int OUT_W = 480
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             sample_valid,
    input logic [OUT_W-1:0] samples
);
    logic seen_start_q;

    // Remember whether a frame boundary has been given since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           seen_start_q <= 1'b0;
        else if (frame_start) seen_start_q <= 1'b1;
    end

    assert_no_valid_unlocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> seen_start_q);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    assert_valid_after_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start ##1 !frame_start |=> sample_valid);

    assert_restart_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !sample_valid);

    assert_hold_samples_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(samples));
endmodule

bind jesd_lane_demapper demap_checker #(.OUT_W(OUT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .sample_valid (sample_valid),
    .samples      (samples)
);

// File: tb/jesd_lane_demapper_tb_top.sv
module jesd_lane_demapper_tb_top;
    localparam int LANES = 8;
    localparam int SPF   = 5;
    localparam int NSMP  = LANES * SPF;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] lane_data = '0;
    logic         frame_start = 1'b0;
    logic [7:0]   lane_invert = '0;
    logic         sample_valid;
    logic [479:0] samples;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    logic [11:0]  smp [LANES][SPF];
    logic [3:0]   tl  [LANES];
    logic         mid_valid;
    logic [479:0] mid_samples;
    logic [479:0] prev_samples;

    always #2 clk = ~clk;

    jesd_lane_demapper dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_data    (lane_data),
        .frame_start  (frame_start),
        .lane_invert  (lane_invert),
        .sample_valid (sample_valid),
        .samples      (samples)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [479:0] act, input logic [479:0] exp_v);
        tests++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp_v);
        tests++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp_v);
        end
    endtask

    function automatic logic [63:0] mk_frame(input int k);
        return {smp[k][0], smp[k][1], smp[k][2], smp[k][3], smp[k][4], tl[k]};
    endfunction

    // R2 encoding: first word low byte is the first octet of the frame.
    function automatic logic [31:0] mk_word(input int k, input int half);
        logic [63:0] f;
        logic [31:0] w;
        f = mk_frame(k);
        for (int o = 0; o < 4; o++) w[8*o +: 8] = f[63 - 8*(o + 4*half) -: 8];
        return w;
    endfunction

    // R4 expected order: slot 8j+k holds sample j of lane k.
    function automatic logic [479:0] expected();
        logic [479:0] e;
        for (int j = 0; j < SPF; j++)
            for (int k = 0; k < LANES; k++)
                e[12*(LANES*j+k) +: 12] = smp[k][j];
        return e;
    endfunction

    task automatic fill(input int seed);
        for (int k = 0; k < LANES; k++) begin
            for (int j = 0; j < SPF; j++)
                smp[k][j] = 12'((seed * 37 + k * 173 + j * 911) ^ (k << j));
            tl[k] = 4'(seed + k);
        end
    endtask

    task automatic drive_half(input int half, input logic fs, input logic [7:0] inv_wire);
        for (int k = 0; k < LANES; k++) begin
            logic [31:0] w;
            w = mk_word(k, half);
            lane_data[32*k +: 32] = inv_wire[k] ? ~w : w;
        end
        frame_start = fs;
    endtask

    // Two words at negedges; capture the mid-frame outputs too.
    task automatic drive_frame(input logic fs, input logic [7:0] inv_wire);
        drive_half(0, fs, inv_wire);
        @(negedge clk);
        mid_valid   = sample_valid;
        mid_samples = samples;
        drive_half(1, 1'b0, inv_wire);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        frame_start = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R1 valid in reset", sample_valid, 1'b0);
        check("R1 samples in reset", samples, '0);
        rst_n = 1'b1;
        for (int c = 0; c < 6; c++) begin
            lane_data = {8{32'hA5C3_0F1E ^ 32'(c * 7919)}};
            @(negedge clk);
            check_bit("R1 no valid before frame_start", sample_valid, 1'b0);
        end
    endtask

    task automatic t_basic();
        fill(3);
        drive_frame(1'b1, 8'h00);
        check_bit("R5 valid after second word", sample_valid, 1'b1);
        check("R2 R4 basic frame", samples, expected());
    endtask

    task automatic t_extremes();
        for (int k = 0; k < LANES; k++) begin
            smp[k][0] = 12'h800; smp[k][1] = 12'h7FF; smp[k][2] = 12'hFFF;
            smp[k][3] = 12'h000; smp[k][4] = 12'(k + 1);
            tl[k] = 4'hF;
        end
        drive_frame(1'b1, 8'h00);
        check("R9 two's complement extremes", samples, expected());
    endtask

    task automatic t_tail();
        logic [479:0] first;
        fill(11);
        for (int k = 0; k < LANES; k++) tl[k] = 4'h0;
        drive_frame(1'b1, 8'h00);
        first = samples;
        for (int k = 0; k < LANES; k++) tl[k] = 4'hF ^ 4'(k);
        drive_frame(1'b1, 8'h00);
        check("R3 tail bits ignored", samples, first);
    endtask

    task automatic t_stream();
        fill(21);
        drive_frame(1'b1, 8'h00);
        check("R5 stream frame 0", samples, expected());
        for (int f = 1; f < 4; f++) begin
            prev_samples = samples;
            fill(21 + f * 5);
            drive_frame(1'b0, 8'h00);
            check_bit("R5 no valid on first word", mid_valid, 1'b0);
            check("R8 samples held between pulses", mid_samples, prev_samples);
            check_bit("R5 valid every second cycle", sample_valid, 1'b1);
            check("R4 stream frame data", samples, expected());
        end
    endtask

    task automatic t_realign();
        fill(40);
        drive_frame(1'b1, 8'h00);
        fill(77);
        drive_half(0, 1'b1, 8'h00);
        @(negedge clk);
        fill(55);
        drive_frame(1'b1, 8'h00);
        check_bit("R6 no valid after restart", mid_valid, 1'b0);
        check_bit("R6 valid after realigned frame", sample_valid, 1'b1);
        check("R6 realigned data", samples, expected());
    endtask

    task automatic t_invert();
        fill(90);
        lane_invert = 8'hA5;
        drive_frame(1'b1, 8'hA5);
        check("R7 inverted lanes restored", samples, expected());
        lane_invert = 8'h00;
        drive_frame(1'b1, 8'h00);
        check("R7 invert cleared", samples, expected());
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_extremes();
        t_tail();
        t_stream();
        t_realign();
        t_invert();
        t_reset();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule